// File: doc/BRIEF.md
# ADC Sample Trigger Generator

This block paces an analog-to-digital converter. Software hands it a sampling interval in nanoseconds through a load strobe. The block turns that request into a count of coarse timer ticks, and it enforces both a floor and a saturating ceiling. The system clock is divided down to a fixed tick of 250 ns, which is 12 cycles of a 48 MHz clock. A period counter then walks through the programmed number of ticks and emits a single-cycle trigger at the start of every period.

A request of zero nanoseconds means "as fast as possible". In that case the timer is held idle and a steady continuous-conversion level is raised instead, so the converter free-runs. Each load strobe halts the timer, installs the new tick count and mode in one step, and restarts counting from the beginning of a period. An enable input gates everything. The block also tracks whether the converter has reported completion since the last trigger, and it flags a trigger that lands on a conversion still outstanding.

Top module: `adc_sample_trigger`

## Requirements
- R1: A request above 1500 ns is loaded as the truncated quotient request/250 ticks (1501 ns gives 6, 1750 ns gives 7, 2000 ns gives 8, 100000 ns gives 400); `active_ticks` shows the loaded count from the cycle after the load edge.
- R2: A request from 1 ns to 1500 ns is loaded as 6 ticks.
- R3: A quotient above 65535 is clamped to 65535 ticks (16383750 ns gives 65535, as do 16384000 ns and 4294967295 ns).
- R4: A request of 0 ns selects continuous mode: while `enable` is high, `cont_level` is 1 and `trig_pulse` stays 0; `active_ticks` reads 6.
- R5: In timed mode, `trig_pulse` is high for exactly one clock per period, and consecutive pulses are 12 × ticks clock cycles apart.
- R6: While `enable` is low, `trig_pulse` and `cont_level` stay 0 and the counters are held at zero; after `enable` is sampled high at an edge, the first trigger appears in the cycle that follows that edge.
- R7: A load strobe sampled at an edge restarts the period: with `enable` high in timed mode, `trig_pulse` is 1 in the cycle after that edge and then repeats at the new period, whatever the phase was before.
- R8: Before the first load after reset, no trigger and no continuous level are produced, even with `enable` high.
- R9: `adc_busy` rises in the cycle after a trigger and falls in the cycle after `adc_done`; it is cleared while the timer is not running. A trigger that arrives while busy is high and `adc_done` is low raises `adc_overrun` for exactly the following cycle.
- R10: During and right after reset all single-bit outputs are 0 and `active_ticks` reads 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (48 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Gates the timer and the continuous level |
| cfg_load | input | 1 | One-cycle strobe: stop, install the request, restart |
| cfg_interval_ns | input | REQ_W | Requested interval in ns; 0 selects continuous mode |
| adc_done | input | 1 | Converter reports that a conversion has finished |
| trig_pulse | output | 1 | One-cycle trigger at the start of each period |
| cont_level | output | 1 | Continuous-conversion level in fast mode |
| adc_busy | output | 1 | A triggered conversion has not yet reported done |
| adc_overrun | output | 1 | One-cycle flag: a trigger hit an outstanding conversion |
| active_ticks | output | CNT_W | Tick count that the timer currently uses |

## Verification
The conversion is tried with a table of requests on both sides of the 1500 ns floor, on exact and inexact multiples of 250 ns, at and beyond the 16-bit ceiling, and at zero. This separates a wrong threshold comparison, a rounding instead of truncating divider and a wrapping instead of clamping count. Trigger spacing is measured for two different tick counts and after a mid-period reload, which tells a correct prescale and restart from an off-by-one or a period that keeps its old phase. The enable, idle and overrun sequences show that gating, the first-pulse timing and the pending flag follow their own state rather than each other.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

   typedef enum logic [1:0] {
      TMODE_IDLE  = 2'd0,
      TMODE_TIMED = 2'd1,
      TMODE_CONT  = 2'd2
   } tmode_e;

   localparam int unsigned DEF_TICK_DIV  = 12;
   localparam int unsigned DEF_TICK_NS   = 250;
   localparam int unsigned DEF_MIN_TICKS = 6;
   localparam int unsigned DEF_CNT_W     = 16;
   localparam int unsigned DEF_REQ_W     = 32;

endpackage

// File: rtl/adc_trig_interval_conv.sv
module adc_trig_interval_conv #(
   parameter int unsigned REQ_W     = 32,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned TICK_NS   = 250,
   parameter int unsigned MIN_TICKS = 6
) (
   input  logic [REQ_W-1:0] req_ns_i,
   output logic [CNT_W-1:0] ticks_o,
   output logic             cont_o
);
   localparam longint unsigned MIN_NS    = longint'(TICK_NS) * longint'(MIN_TICKS);
   localparam longint unsigned MAX_TICKS = (longint'(1) << CNT_W) - 1;

   initial begin
      assert (TICK_NS >= 1) else $error("TICK_NS must be at least 1");
      assert (CNT_W < REQ_W) else $error("CNT_W must be narrower than REQ_W");
      assert (longint'(MIN_TICKS) <= MAX_TICKS && MIN_TICKS >= 2)
         else $error("MIN_TICKS out of range");
   end

   logic [REQ_W-1:0] quot;

   always_comb begin
      quot    = req_ns_i / REQ_W'(TICK_NS);
      cont_o  = (req_ns_i == '0);
      if (req_ns_i <= REQ_W'(MIN_NS))
         ticks_o = CNT_W'(MIN_TICKS);
      else if (quot > REQ_W'(MAX_TICKS))
         ticks_o = CNT_W'(MAX_TICKS);
      else
         ticks_o = quot[CNT_W-1:0];
   end

endmodule

// File: rtl/adc_trig_prescaler.sv
module adc_trig_prescaler #(
   parameter int unsigned TICK_DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   output logic tick_o,
   output logic at_zero_o
);
   initial begin
      assert (TICK_DIV >= 1) else $error("TICK_DIV must be at least 1");
   end

   generate
      if (TICK_DIV == 1) begin : g_passthru
         assign tick_o    = 1'b1;
         assign at_zero_o = 1'b1;
      end else begin : g_count
         localparam int unsigned PW = $clog2(TICK_DIV);
         localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
         logic [PW-1:0] pre_q;

         always_ff @(posedge clk) begin
            if (!rst_n || clear_i)
               pre_q <= '0;
            else if (pre_q == LAST)
               pre_q <= '0;
            else
               pre_q <= pre_q + 1'b1;
         end

         assign tick_o    = (pre_q == LAST);
         assign at_zero_o = (pre_q == '0);

         assert_presc_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
            pre_q <= LAST);
      end
   endgenerate

endmodule

// File: rtl/adc_trig_period_cnt.sv
module adc_trig_period_cnt #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] period_i,
   output logic             at_zero_o
);
   logic [CNT_W-1:0] per_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i)
         per_q <= '0;
      else if (tick_i) begin
         if (per_q >= period_i - CNT_W'(1))
            per_q <= '0;
         else
            per_q <= per_q + 1'b1;
      end
   end

   assign at_zero_o = (per_q == '0);

   assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      per_q < period_i);

endmodule

// File: rtl/adc_trig_overrun.sv
module adc_trig_overrun (
   input  logic clk,
   input  logic rst_n,
   input  logic flush_i,
   input  logic trig_i,
   input  logic done_i,
   output logic busy_o,
   output logic ovr_o
);
   logic busy_q;
   logic ovr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         ovr_q <= trig_i && busy_q && !done_i;
         if (flush_i)
            busy_q <= 1'b0;
         else if (trig_i)
            busy_q <= 1'b1;
         else if (done_i)
            busy_q <= 1'b0;
      end
   end

   assign busy_o = busy_q;
   assign ovr_o  = ovr_q;

   assert_ovr_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_q |-> $past(busy_q));
   assert_ovr_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_q |=> !ovr_q);
   assert_busy_on_trig_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && !flush_i) |=> busy_q);

endmodule

// File: rtl/adc_sample_trigger.sv
module adc_sample_trigger
   import adc_trig_pkg::*;
#(
   parameter int unsigned TICK_DIV  = DEF_TICK_DIV,
   parameter int unsigned TICK_NS   = DEF_TICK_NS,
   parameter int unsigned MIN_TICKS = DEF_MIN_TICKS,
   parameter int unsigned CNT_W     = DEF_CNT_W,
   parameter int unsigned REQ_W     = DEF_REQ_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             cfg_load,
   input  logic [REQ_W-1:0] cfg_interval_ns,
   input  logic             adc_done,
   output logic             trig_pulse,
   output logic             cont_level,
   output logic             adc_busy,
   output logic             adc_overrun,
   output logic [CNT_W-1:0] active_ticks
);
   localparam logic [CNT_W-1:0] RST_TICKS = CNT_W'(MIN_TICKS);

   tmode_e           mode_q, mode_d;
   logic [CNT_W-1:0] ticks_q;
   logic [CNT_W-1:0] conv_ticks;
   logic             conv_cont;
   logic             run_q, cont_q;
   logic             clr_cnt;
   logic             tick, pre_zero, per_zero;

   adc_trig_interval_conv #(
      .REQ_W(REQ_W), .CNT_W(CNT_W), .TICK_NS(TICK_NS), .MIN_TICKS(MIN_TICKS)
   ) u_conv (
      .req_ns_i(cfg_interval_ns),
      .ticks_o (conv_ticks),
      .cont_o  (conv_cont)
   );

   always_comb begin
      mode_d = mode_q;
      if (cfg_load)
         mode_d = conv_cont ? TMODE_CONT : TMODE_TIMED;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= TMODE_IDLE;
         ticks_q <= RST_TICKS;
         run_q   <= 1'b0;
         cont_q  <= 1'b0;
      end else begin
         mode_q <= mode_d;
         if (cfg_load)
            ticks_q <= conv_ticks;
         run_q  <= enable && (mode_d == TMODE_TIMED);
         cont_q <= enable && (mode_d == TMODE_CONT);
      end
   end

   assign clr_cnt = cfg_load || !run_q;

   adc_trig_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (clr_cnt),
      .tick_o   (tick),
      .at_zero_o(pre_zero)
   );

   adc_trig_period_cnt #(.CNT_W(CNT_W)) u_per (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (clr_cnt),
      .tick_i   (tick),
      .period_i (ticks_q),
      .at_zero_o(per_zero)
   );

   assign trig_pulse   = run_q && pre_zero && per_zero;
   assign cont_level   = cont_q;
   assign active_ticks = ticks_q;

   adc_trig_overrun u_ovr (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush_i(!run_q),
      .trig_i (trig_pulse),
      .done_i (adc_done),
      .busy_o (adc_busy),
      .ovr_o  (adc_overrun)
   );

   assert_trig_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |=> !trig_pulse);
   assert_gate_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!trig_pulse && !cont_level));
   assert_cont_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cont_level |-> !trig_pulse);
   assert_ticks_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
      active_ticks >= RST_TICKS);
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == TMODE_IDLE) |-> (!trig_pulse && !cont_level));
   assert_load_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_load && enable && !conv_cont) |=> trig_pulse);

endmodule

// File: tb/sim_adc_sample_trigger.sv
module sim_adc_sample_trigger;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [31:0] ns;
      logic [15:0] ticks;
      logic        cont;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VEC [NV] = '{
      '{32'd0,          16'd6,     1'b1},
      '{32'd1,          16'd6,     1'b0},
      '{32'd1500,       16'd6,     1'b0},
      '{32'd1501,       16'd6,     1'b0},
      '{32'd1749,       16'd6,     1'b0},
      '{32'd1750,       16'd7,     1'b0},
      '{32'd2000,       16'd8,     1'b0},
      '{32'd100000,     16'd400,   1'b0},
      '{32'd16383750,   16'd65535, 1'b0},
      '{32'd16384000,   16'd65535, 1'b0},
      '{32'hFFFFFFFF,   16'd65535, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        cfg_load = 1'b0;
   logic [31:0] cfg_interval_ns = '0;
   logic        adc_done = 1'b0;
   logic        trig_pulse, cont_level, adc_busy, adc_overrun;
   logic [15:0] active_ticks;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_sample_trigger u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_load(cfg_load),
      .cfg_interval_ns(cfg_interval_ns), .adc_done(adc_done),
      .trig_pulse(trig_pulse), .cont_level(cont_level), .adc_busy(adc_busy),
      .adc_overrun(adc_overrun), .active_ticks(active_ticks)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic load(input logic [31:0] ns);
      @(negedge clk);
      cfg_interval_ns = ns;
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
   endtask

   task automatic wait_trig(input int limit, output int n);
      n = -1;
      for (int k = 1; k <= limit; k++) begin
         @(negedge clk);
         if (trig_pulse) begin
            n = k;
            break;
         end
      end
   endtask

   task automatic count_pulses(input int cycles, output int trigs, output int conts);
      trigs = 0;
      conts = 0;
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         if (trig_pulse) trigs++;
         if (cont_level) conts++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int n, t, c;
      string tag;

      // R10: reset state
      repeat (3) @(negedge clk);
      chk("R10 trig", trig_pulse, 0);
      chk("R10 cont", cont_level, 0);
      chk("R10 busy", adc_busy, 0);
      chk("R10 ovr", adc_overrun, 0);
      chk("R10 ticks", active_ticks, 6);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 ticks after release", active_ticks, 6);

      // R8: enabled but never loaded
      enable = 1'b1;
      count_pulses(150, t, c);
      chk("R8 no trigger before load", t, 0);
      chk("R8 no cont before load", c, 0);

      // Table walk: conversion R1 R2 R3 R4
      for (int i = 0; i < NV; i++) begin
         if (VEC[i].cont) tag = "R4";
         else if (VEC[i].ns <= 1500) tag = "R2";
         else if (VEC[i].ticks == 16'd65535) tag = "R3";
         else tag = "R1";
         load(VEC[i].ns);
         chk({tag, " ticks"}, active_ticks, VEC[i].ticks);
         chk({tag, " cont"}, cont_level, VEC[i].cont);
         chk({tag, " trig at load"}, trig_pulse, !VEC[i].cont);
      end

      // R5: period and width at 7 ticks
      load(32'd1750);
      chk("R7 trig after load", trig_pulse, 1);
      @(negedge clk);
      chk("R5 pulse one cycle", trig_pulse, 0);
      wait_trig(400, n);
      chk("R5 spacing 7 ticks", n + 1, 84);
      wait_trig(400, n);
      chk("R5 spacing repeat", n, 84);

      // R7: reload mid-period
      repeat (30) @(negedge clk);
      load(32'd2000);
      chk("R7 restart trig", trig_pulse, 1);
      wait_trig(400, n);
      chk("R7 new period 8 ticks", n, 96);

      // R4: continuous mode
      load(32'd0);
      chk("R4 cont level", cont_level, 1);
      count_pulses(300, t, c);
      chk("R4 no triggers", t, 0);
      chk("R4 cont held", c, 300);

      // R6: enable gating
      @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      chk("R6 cont off", cont_level, 0);
      load(32'd1500);
      chk("R6 no trig while disabled", trig_pulse, 0);
      count_pulses(200, t, c);
      chk("R6 quiet while disabled", t + c, 0);
      chk("R9 busy cleared when stopped", adc_busy, 0);
      enable = 1'b1;
      @(negedge clk);
      chk("R6 first trig after enable", trig_pulse, 1);
      chk("R9 busy low at trigger", adc_busy, 0);
      @(negedge clk);
      chk("R9 busy after trigger", adc_busy, 1);
      chk("R9 no overrun yet", adc_overrun, 0);

      // R9: overrun without done
      wait_trig(400, n);
      chk("R6 period 6 ticks", n + 1, 72);
      @(negedge clk);
      chk("R9 overrun pulse", adc_overrun, 1);
      adc_done = 1'b1;
      @(negedge clk);
      adc_done = 1'b0;
      chk("R9 overrun one cycle", adc_overrun, 0);
      @(negedge clk);
      chk("R9 busy cleared by done", adc_busy, 0);
      wait_trig(400, n);
      @(negedge clk);
      chk("R9 no overrun after done", adc_overrun, 0);
      chk("R9 busy again", adc_busy, 1);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule